// File: doc/BRIEF.md
# Up/Down Event Counter Channel

This block is one channel of a performance-monitoring unit. A 32-bit control word, written by software, picks one event signal that makes the counter count up and a second event signal that makes it count down. Both are picked from a shared event bus. The bus is arranged as a number of ports. Every port carries the same set of event codes, so a selection is a (port, code) pair.

Each direction has its own mode:
- In level mode the counter moves on every clock where the selected event is high.
- In edge mode the counter moves once for each 0-to-1 transition of the event.

Counting happens only while the counting-enable input is high. When an up step and a down step land on the same clock, they cancel. The counter can also be loaded directly. Writes to the control word take effect on the next clock, with no staging copy. Both the control word and the counter are always visible on read-data outputs, and reading them has no side effects.

Top module: `perf_chan`

## Requirements
- R1: After reset the control word reads 0 and the counter reads 0.
- R2: A control write replaces all fields in one clock. The written value reads back on the next cycle, and the new selection governs counting from that cycle on.
- R3: Control word layout, from most to least significant bit: down mode (bit 31), down port (30:28), down code (27:16), up mode (bit 15), up port (14:12), up code (11:0). A mode bit of 0 means level mode and 1 means edge mode. The event for (port p, code c) is bus bit p*NUM_CODES+c, where NUM_CODES defaults to 16.
- R4: In level mode the counter changes by one on every enabled clock where the selected event is high.
- R5: In edge mode the counter changes by one only on a clock where the selected event is 1 and was 0 on the previous clock. On the first clock after a control write, no edge is ever seen, even if the newly selected event is already high.
- R6: When an up step and a down step are due on the same clock, the counter keeps its value.
- R7: While count_en is low, the counter does not change, whatever the events do.
- R8: A counter load sets the counter to the written value on the next cycle and takes priority over any step due on that clock.
- R9: The counter wraps modulo 2^CNT_W. Stepping up from all ones gives 0, and stepping down from 0 gives all ones.
- R10: A code of NUM_CODES or more, or a port of NUM_PORTS or more, selects a constant-zero event that never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| count_en | input | 1 | Counting enable |
| ev_bus | input | NUM_PORTS*NUM_CODES | Event bus, bit p*NUM_CODES+c is code c of port p |
| cfg_rdata | output | 32 | Current control word |
| cnt_value | output | CNT_W | Current counter value |

## Verification
The embedded properties check the following on every cycle:
- the counter never moves by more than one per clock;
- the counter holds while counting is disabled or when up and down coincide;
- a load wins over a step;
- an edge-mode hit never repeats on the following clock;
- a control write is visible on the next cycle.

Other behaviours depend on which bus bit is selected and on absolute counts, so only the bench scenarios can show them. These are:
- the bit layout of the control word and the port/code mapping onto the bus;
- wrap-around in both directions;
- out-of-range codes;
- suppression of the false edge right after a selection change.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int CFG_W  = 32;
  localparam int CODE_W = 12;
  localparam int PORT_W = 3;

  typedef struct packed {
    logic              dn_edge;
    logic [PORT_W-1:0] dn_port;
    logic [CODE_W-1:0] dn_code;
    logic              up_edge;
    logic [PORT_W-1:0] up_port;
    logic [CODE_W-1:0] up_code;
  } pmc_cfg_t;
endpackage

// File: rtl/pmc_evsel.sv
module pmc_evsel
  import pmc_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_CODES = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PORTS*NUM_CODES-1:0] ev_bus,
  input  logic [PORT_W-1:0]            port,
  input  logic [CODE_W-1:0]            code,
  input  logic                         edge_mode,
  input  logic                         sel_wr,
  output logic                         hit
);
  localparam int BUS_W = NUM_PORTS * NUM_CODES;
  localparam int IDX_W = (BUS_W > 1) ? $clog2(BUS_W) : 1;

  logic [31:0] idx_full;
  logic        in_range;
  logic        lvl;
  logic        hist_d, hist_q;

  always_comb begin
    in_range = (32'(port) < 32'(NUM_PORTS)) && (32'(code) < 32'(NUM_CODES));
    idx_full = 32'(port) * 32'(NUM_CODES) + 32'(code);
    lvl      = in_range ? ev_bus[idx_full[IDX_W-1:0]] : 1'b0;
    // a selection change masks the first cycle so no false edge appears
    hist_d   = sel_wr ? 1'b1 : lvl;
    hit      = edge_mode ? (lvl & ~hist_q) : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= hist_d;
  end

  assert_edge_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && hit && !sel_wr) |=> !hit);
  assert_no_edge_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> !(edge_mode && hit));
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             up,
  input  logic             dn,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = ld | (en & (up ^ dn));
    cnt_d  = cnt_q;
    if (ld)             cnt_d = ld_val;
    else if (en && up)  cnt_d = cnt_q + ONE;
    else if (en && dn)  cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> (cnt == $past(cnt)));
  assert_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld && up && dn) |=> (cnt == $past(cnt)));
  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));
  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ld) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + ONE) ||
                     (cnt == $past(cnt) - ONE)));
endmodule

// File: rtl/perf_chan.sv
module perf_chan
  import pmc_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_CODES = 16,
  parameter int CNT_W     = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic [CFG_W-1:0]               cfg_wdata,
  input  logic                           cnt_we,
  input  logic [CNT_W-1:0]               cnt_wdata,
  input  logic                           count_en,
  input  logic [NUM_PORTS*NUM_CODES-1:0] ev_bus,
  output logic [CFG_W-1:0]               cfg_rdata,
  output logic [CNT_W-1:0]               cnt_value
);
  pmc_cfg_t cfg_q, cfg_d;

  logic [PORT_W-1:0] sel_port [2];
  logic [CODE_W-1:0] sel_code [2];
  logic              sel_edge [2];
  logic              dir_hit  [2];

  always_comb begin
    cfg_d = cfg_we ? pmc_cfg_t'(cfg_wdata) : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    sel_port[0] = cfg_q.up_port;
    sel_code[0] = cfg_q.up_code;
    sel_edge[0] = cfg_q.up_edge;
    sel_port[1] = cfg_q.dn_port;
    sel_code[1] = cfg_q.dn_code;
    sel_edge[1] = cfg_q.dn_edge;
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    pmc_evsel #(
      .NUM_PORTS(NUM_PORTS),
      .NUM_CODES(NUM_CODES)
    ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_bus    (ev_bus),
      .port      (sel_port[d]),
      .code      (sel_code[d]),
      .edge_mode (sel_edge[d]),
      .sel_wr    (cfg_we),
      .hit       (dir_hit[d])
    );
  end

  pmc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (count_en),
    .up     (dir_hit[0]),
    .dn     (dir_hit[1]),
    .ld     (cnt_we),
    .ld_val (cnt_wdata),
    .cnt    (cnt_value)
  );

  assign cfg_rdata = cfg_q;

  assert_cfg_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == $past(cfg_wdata)));
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> (cfg_rdata == $past(cfg_rdata)));
endmodule

// File: tb/perf_chan_tb.sv
module perf_chan_tb;
  localparam int NP = 8;
  localparam int NC = 16;
  localparam int CW = 32;
  localparam int BW = NP * NC;

  typedef struct packed {
    logic [31:0]   cfg;
    logic [CW-1:0] load;
    logic [BW-1:0] ev;
    logic [7:0]    ncyc;
    logic [CW-1:0] exp;
  } vec_t;

  // up/down/field-layout scenarios (R3 layout used for every cfg word)
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'h0FFF_0003, 32'd100, 128'h8, 8'd5, 32'd105},                    // R4 up level p0 c3
    '{32'h2005_0FFF, 32'd10,  128'h20_0000_0000, 8'd4, 32'd6},           // R4 down level p2 c5
    '{32'h1007_1007, 32'd50,  128'h80_0000, 8'd6, 32'd50},               // R6 both same event
    '{32'h0FFF_F00F, 32'd0,   {1'b1, 127'd0}, 8'd8, 32'd1},              // R5 up edge p7 c15
    '{32'hB001_0FFF, 32'd20,  128'h2_0000_0000_0000, 8'd8, 32'd19},      // R5 down edge p3 c1
    '{32'h0FFF_0000, 32'hFFFF_FFFE, 128'h1, 8'd3, 32'd1},                // R9 wrap up
    '{32'h0000_0FFF, 32'd1,   128'h1, 8'd3, 32'hFFFF_FFFE},              // R9 wrap down
    '{32'h0FFF_0010, 32'd7,   ~128'h0, 8'd5, 32'd7},                     // R10 code out of range
    '{32'h8001_0000, 32'd0,   128'h3, 8'd5, 32'd4}                       // R6 level up vs edge down
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [31:0]   cfg_wdata;
  logic          cnt_we;
  logic [CW-1:0] cnt_wdata;
  logic          count_en;
  logic [BW-1:0] ev_bus;
  logic [31:0]   cfg_rdata;
  logic [CW-1:0] cnt_value;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  perf_chan #(.NUM_PORTS(NP), .NUM_CODES(NC), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .count_en(count_en),
    .ev_bus(ev_bus), .cfg_rdata(cfg_rdata), .cnt_value(cnt_value)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic load_cnt(input logic [CW-1:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    tick();
    cnt_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; cnt_we = 1'b0;
    cnt_wdata = '0; count_en = 1'b0; ev_bus = '0;
    repeat (3) @(negedge clk);
    check("R1 cfg reset", cfg_rdata, 32'h0);
    check("R1 cnt reset", cnt_value, 32'h0);
    rst_n = 1'b1;
    tick();
    check("R1 cfg after release", cfg_rdata, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      ev_bus = '0;
      write_cfg(VEC[i].cfg);
      check("R2 readback", cfg_rdata, VEC[i].cfg);
      load_cnt(VEC[i].load);
      ev_bus = VEC[i].ev;
      count_en = 1'b1;
      for (int k = 0; k < int'(VEC[i].ncyc); k++) tick();
      count_en = 1'b0;
      check($sformatf("R3 vector %0d", i), cnt_value, VEC[i].exp);
    end

    // R7: disabled counting ignores an active level event
    ev_bus = '0;
    write_cfg(32'h0FFF_0003);
    load_cnt(32'd40);
    ev_bus = 128'h8;
    repeat (5) tick();
    check("R7 hold while disabled", cnt_value, 32'd40);

    // R8: load wins over a pending up step
    count_en = 1'b1;
    cnt_we = 1'b1; cnt_wdata = 32'd900;
    tick();
    cnt_we = 1'b0; count_en = 1'b0;
    check("R8 load priority", cnt_value, 32'd900);

    // R5: newly selected event already high gives no edge after the write
    ev_bus = 128'h10;
    write_cfg(32'h0FFF_0FFF);
    load_cnt(32'd5);
    count_en = 1'b1;
    write_cfg(32'h0FFF_8004);
    repeat (3) tick();
    count_en = 1'b0;
    check("R5 no false edge after write", cnt_value, 32'd5);

    // R2: new level selection counts from the cycle after the write
    count_en = 1'b1;
    write_cfg(32'h0FFF_0004);
    tick();
    count_en = 1'b0;
    check("R2 selection effective next cycle", cnt_value, 32'd6);

    // R10: port and code in range but port beyond NP impossible at 8; code 15 max valid
    ev_bus = {1'b0, {127{1'b1}}};
    write_cfg(32'h0FFF_7010);
    count_en = 1'b1;
    repeat (3) tick();
    count_en = 1'b0;
    check("R10 code 16 on port 7 ignored", cnt_value, 32'd6);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule